// File: doc/BRIEF.md
# Partitioned Fixed-Point Multiply-Add Lane

This block is one arithmetic datapath slice of a vector unit. It takes a packed vector word and treats it, for each operation, as a set of equal signed elements: four of 64 bits, eight of 32 bits, or sixteen of 16 bits with the default 256-bit word. Every element of the word is processed in parallel. Carries, borrows and shifted-out bits never leak from one element into its neighbour.

The operation set covers fixed-point and saturating integer arithmetic. The main operation is a fused multiply-add. It multiplies the low halves of two operands, shifts the product right with rounding, and adds a third full-width operand, saturating the sum. The other operations are a rounding right shift, a saturating left shift, saturating add and subtract, and signed minimum and maximum. Operands arrive with a valid strobe. The packed result and its valid flag appear registered one clock later.

Top module: `pfx_lane`

## Requirements
- R1: `ew` selects the element width n: code 0 gives 16-bit elements, 1 gives 32-bit, and 2 or 3 give 64-bit; element k occupies bits [k*n +: n] of every operand and of the result.
- R2: For `op` = 0 (multiply-add), each element's low n/2 bits of `src_x` and `src_y` are taken as signed values and multiplied exactly into an n-bit signed product.
- R3: The multiply-add product and the shifted operand of `op` = 1 are shifted right arithmetically by s = `shamt` mod n with round-half-up (2^(s-1) is added first); s = 0 leaves the value unrounded.
- R4: The multiply-add adds the rounded product to the element of `src_z` and clamps the sum to the signed n-bit range instead of wrapping.
- R5: `op` = 1 returns the element of `src_x` shifted right with rounding as in R3.
- R6: `op` = 2 shifts the element of `src_x` left by s; if any bit shifted out differs from the resulting sign bit, the result is the signed maximum (source non-negative) or minimum (source negative).
- R7: `op` = 3 is x+y and `op` = 4 is x-y, per element, both clamped to the signed n-bit range.
- R8: `op` = 5 returns the signed minimum and `op` = 6 the signed maximum of the `src_x` and `src_y` elements; `op` = 7 returns zero.
- R9: No element's result depends on the bits of any other element, at every width.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result` then holds the outcome of that input.
- R11: After reset `out_valid` and `result` are zero; a cycle without `in_valid` leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 3 | Operation code (see R2 to R8) |
| ew | input | 2 | Element width code (see R1) |
| src_x | input | DATA_W | First packed operand |
| src_y | input | DATA_W | Second packed operand |
| src_z | input | DATA_W | Accumulate operand for multiply-add |
| shamt | input | 6 | Shift amount, taken modulo the element width |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | DATA_W | Packed result |

## Verification
The bench builds the lane with the default 256-bit word, so all three partitionings carry several elements at once: sixteen 16-bit, eight 32-bit, and four 64-bit elements. Directed words that sit at the saturation edges of every element expose any carry or borrow crossing a boundary. A 6-bit shift amount used on 16- and 32-bit elements checks the modulo reduction of the shift. Random words, shifts and width codes, all four codes included, are compared each clock against a wide-integer model. Idle cycles mixed into the stimulus check the hold behaviour.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int NARROW_W = 16;
    localparam int SHAMT_W  = 6;   // enough for the widest 64-bit element

    typedef enum logic [2:0] {
        OP_MADD = 3'd0,
        OP_SHRR = 3'd1,
        OP_SHLS = 3'd2,
        OP_ADDS = 3'd3,
        OP_SUBS = 3'd4,
        OP_MIN  = 3'd5,
        OP_MAX  = 3'd6,
        OP_ZERO = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        EW_16  = 2'd0,
        EW_32  = 2'd1,
        EW_64  = 2'd2,
        EW_64B = 2'd3
    } ew_e;

endpackage

// File: rtl/pfx_elem.sv
// One signed element of width W: all operations, purely combinational.
module pfx_elem
    import pfx_pkg::*;
#(
    parameter int W    = 16,
    parameter int SH_W = $clog2(W)
) (
    input  logic [2:0]      op,
    input  logic [W-1:0]    xa,
    input  logic [W-1:0]    xb,
    input  logic [W-1:0]    xc,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    y
);

    localparam int H = W / 2;

    // clamp a (W+1)-bit two's complement value into W bits
    function automatic logic [W-1:0] clamp(input logic [W:0] v);
        if (v[W] != v[W-1])
            return v[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        return v[W-1:0];
    endfunction

    // arithmetic right shift with round-half-up; s == 0 passes through
    function automatic logic [W-1:0] shr_round(input logic [W-1:0] v,
                                               input logic [SH_W-1:0] s);
        logic signed [W:0] e;
        logic        [W:0] rb;
        e  = $signed({v[W-1], v});
        rb = '0;
        if (s != '0) rb = (W+1)'(1) << (s - 1'b1);
        e = e + $signed(rb);
        e = e >>> s;
        return e[W-1:0];
    endfunction

    logic signed [W-1:0]   half_a;
    logic signed [W-1:0]   half_b;
    logic signed [W-1:0]   prod;
    logic        [W-1:0]   prod_rnd;
    logic        [W:0]     acc_sum;
    logic        [2*W-1:0] shl_wide;
    logic                  shl_fits;
    logic        [W:0]     add_sum;
    logic        [W:0]     sub_dif;
    logic                  x_lt_y;

    always_comb begin
        half_a   = $signed({{H{xa[H-1]}}, xa[H-1:0]});
        half_b   = $signed({{H{xb[H-1]}}, xb[H-1:0]});
        prod     = half_a * half_b;
        prod_rnd = shr_round(prod, sh);
        acc_sum  = {xc[W-1], xc} + {prod_rnd[W-1], prod_rnd};

        shl_wide = {{W{xa[W-1]}}, xa} << sh;
        shl_fits = (&shl_wide[2*W-1:W-1]) | ~(|shl_wide[2*W-1:W-1]);

        add_sum  = {xa[W-1], xa} + {xb[W-1], xb};
        sub_dif  = {xa[W-1], xa} - {xb[W-1], xb};
        x_lt_y   = $signed(xa) < $signed(xb);

        unique case (op_e'(op))
            OP_MADD: y = clamp(acc_sum);
            OP_SHRR: y = shr_round(xa, sh);
            OP_SHLS: y = shl_fits ? shl_wide[W-1:0]
                       : (xa[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}});
            OP_ADDS: y = clamp(add_sum);
            OP_SUBS: y = clamp(sub_dif);
            OP_MIN:  y = x_lt_y ? xa : xb;
            OP_MAX:  y = x_lt_y ? xb : xa;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pfx_part.sv
// A full packed word cut into DATA_W/ELEM_W independent elements.
module pfx_part #(
    parameter int DATA_W = 256,
    parameter int ELEM_W = 16,
    parameter int SH_W   = $clog2(ELEM_W)
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_x,
    input  logic [DATA_W-1:0] src_y,
    input  logic [DATA_W-1:0] src_z,
    input  logic [SH_W-1:0]   sh,
    output logic [DATA_W-1:0] part_res
);

    localparam int N_ELEM = DATA_W / ELEM_W;

    for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
        pfx_elem #(.W(ELEM_W), .SH_W(SH_W)) u_elem (
            .op (op),
            .xa (src_x[k*ELEM_W +: ELEM_W]),
            .xb (src_y[k*ELEM_W +: ELEM_W]),
            .xc (src_z[k*ELEM_W +: ELEM_W]),
            .sh (sh),
            .y  (part_res[k*ELEM_W +: ELEM_W])
        );
    end

endmodule

// File: rtl/pfx_lane.sv
module pfx_lane
    import pfx_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [1:0]         ew,
    input  logic [DATA_W-1:0]  src_x,
    input  logic [DATA_W-1:0]  src_y,
    input  logic [DATA_W-1:0]  src_z,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result
);

    localparam int N_WIDTHS = 3;   // 16, 32, 64

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } lane_st_t;

    lane_st_t          st_d, st_q;
    logic [DATA_W-1:0] part_res [N_WIDTHS];
    logic [DATA_W-1:0] sel_res;

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int EW_BITS = NARROW_W << g;
        localparam int EW_SH   = $clog2(EW_BITS);
        pfx_part #(.DATA_W(DATA_W), .ELEM_W(EW_BITS), .SH_W(EW_SH)) u_part (
            .op       (op),
            .src_x    (src_x),
            .src_y    (src_y),
            .src_z    (src_z),
            .sh       (shamt[EW_SH-1:0]),
            .part_res (part_res[g])
        );
    end

    always_comb begin
        unique case (ew_e'(ew))
            EW_16:   sel_res = part_res[0];
            EW_32:   sel_res = part_res[1];
            default: sel_res = part_res[2];
        endcase
        st_d      = st_q;
        st_d.vld  = in_valid;
        if (in_valid) st_d.data = sel_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.data;

endmodule

// File: rtl/pfx_lane_chk.sv
module pfx_lane_chk
    import pfx_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [2:0]         op,
    input logic [1:0]         ew,
    input logic [DATA_W-1:0]  src_x,
    input logic [DATA_W-1:0]  src_y,
    input logic [DATA_W-1:0]  src_z,
    input logic [SHAMT_W-1:0] shamt,
    input logic               out_valid,
    input logic [DATA_W-1:0]  result
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                           // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                         // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));                                    // R11
    AST_ADDS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADDS && ew == EW_16 && !src_x[15] && !src_y[15])
        |=> !result[15]);                                                  // R7
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MIN && ew == EW_16)
        |=> $signed(result[15:0]) <= $signed($past(src_x[15:0])));        // R8
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MAX && ew == EW_16)
        |=> $signed(result[15:0]) >= $signed($past(src_y[15:0])));        // R8
    AST_ZERO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ZERO) |=> result == '0);                     // R8

    logic unused_ok;
    assign unused_ok = ^{src_z, shamt};

endmodule

bind pfx_lane pfx_lane_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .ew        (ew),
    .src_x     (src_x),
    .src_y     (src_y),
    .src_z     (src_z),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_pfx_lane.sv
module tb_pfx_lane;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    op = '0;
    logic [1:0]    ew = '0;
    logic [DW-1:0] src_x = '0, src_y = '0, src_z = '0;
    logic [5:0]    shamt = '0;
    logic          out_valid;
    logic [DW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    logic          exp_vld = 1'b0;
    logic [DW-1:0] exp_res = '0;
    string         exp_tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    pfx_lane #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ew(ew),
        .src_x(src_x), .src_y(src_y), .src_z(src_z), .shamt(shamt),
        .out_valid(out_valid), .result(result)
    );

    // ---------------- behavioural reference on wide integers ----------------
    function automatic logic signed [129:0] sx(input logic [63:0] v, input int w);
        logic signed [129:0] t;
        t = $signed({v, 66'b0});
        t = t <<< (64 - w);
        return t >>> (130 - w);
    endfunction

    function automatic logic signed [129:0] satn(input logic signed [129:0] v, input int n);
        logic signed [129:0] mx, mn;
        mx = (130'sd1 <<< (n - 1)) - 130'sd1;
        mn = -(130'sd1 <<< (n - 1));
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    function automatic logic signed [129:0] rshr(input logic signed [129:0] v, input int s);
        if (s == 0) return v;
        return (v + (130'sd1 <<< (s - 1))) >>> s;
    endfunction

    function automatic logic [DW-1:0] ref_word(input int o, input int e,
        input logic [DW-1:0] x, input logic [DW-1:0] y, input logic [DW-1:0] z, input int sh);
        int n, s;
        logic [DW-1:0] acc, mask;
        logic signed [129:0] a, b, c, v;
        n = (e == 0) ? 16 : (e == 1) ? 32 : 64;
        s = sh % n;
        acc = '0;
        mask = (DW'(1) << n) - DW'(1);
        for (int k = 0; k < DW / n; k++) begin
            a = sx(64'(x >> (k * n)), n);
            b = sx(64'(y >> (k * n)), n);
            c = sx(64'(z >> (k * n)), n);
            case (o)
                0: v = satn(c + rshr(sx(64'(a), n / 2) * sx(64'(b), n / 2), s), n);
                1: v = rshr(a, s);
                2: v = satn(a <<< s, n);
                3: v = satn(a + b, n);
                4: v = satn(a - b, n);
                5: v = (a < b) ? a : b;
                6: v = (a < b) ? b : a;
                default: v = '0;
            endcase
            acc = acc | ((DW'(v[63:0]) & mask) << (k * n));
        end
        return acc;
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0: return "R2 R3 R4 R1 R9 R10";
            1: return "R5 R3 R1 R9 R10";
            2: return "R6 R1 R9 R10";
            3, 4: return "R7 R1 R9 R10";
            default: return "R8 R1 R9 R10";
        endcase
    endfunction

    task automatic check_now();
        n_checks++;
        if (out_valid !== exp_vld || result !== exp_res) begin
            n_fail++;
            $display("FAIL [%s] got vld=%0b res=%h exp vld=%0b res=%h",
                     exp_tag, out_valid, result, exp_vld, exp_res);
        end
    endtask

    // compare the previous expectation, then drive the next input
    task automatic step(input logic v, input int o, input int e,
                        input logic [DW-1:0] x, input logic [DW-1:0] y,
                        input logic [DW-1:0] z, input int sh);
        @(negedge clk);
        check_now();
        in_valid = v; op = 3'(o); ew = 2'(e);
        src_x = x; src_y = y; src_z = z; shamt = 6'(sh);
        exp_vld = v;
        if (v) begin
            exp_res = ref_word(o, e, x, y, z, sh);
            exp_tag = tag_of(o);
        end else begin
            exp_tag = "R11 R10 idle";
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL [watchdog] got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL [R11 reset] got vld=%0b res=%h exp vld=0 res=0", out_valid, result);
        end
        rst_n = 1'b1;
        // R4: -128 * -128 = 16384 plus 0x7fff saturates at every 16-bit element
        step(1, 0, 0, {16{16'h0080}}, {16{16'h0080}}, {16{16'h7fff}}, 0);
        // R3: odd product, shift 1 rounds up half
        step(1, 0, 0, {16{16'h0003}}, {16{16'h0001}}, '0, 1);
        // R3: shift amount 17 on 16-bit elements reduces to 1
        step(1, 0, 0, {16{16'h0005}}, {16{16'h0001}}, '0, 17);
        // R5: rounding shift, negative values, 32-bit elements
        step(1, 1, 1, {8{32'hffff_fffb}}, '0, '0, 1);
        // R5: shift 0 leaves value unchanged at 64-bit
        step(1, 1, 2, rnd_word(), '0, '0, 0);
        // R6: left shift saturates positive and negative
        step(1, 2, 0, {8{16'h4000, 16'hc000}}, '0, '0, 2);
        step(1, 2, 0, {8{16'h0001, 16'hffff}}, '0, '0, 14);
        // R7: add overflow and subtract underflow at 64-bit boundaries (R9)
        step(1, 3, 2, {4{64'h7fff_ffff_ffff_ffff}}, {4{64'h1}}, '0, 0);
        step(1, 4, 3, {4{64'h8000_0000_0000_0000}}, {4{64'h1}}, '0, 0);
        // R9: 16-bit wrap limits in every element must not carry out
        step(1, 3, 0, {16{16'hffff}}, {16{16'h0001}}, '0, 0);
        // R8: min, max and zero op
        step(1, 5, 0, rnd_word(), rnd_word(), '0, 0);
        step(1, 6, 1, rnd_word(), rnd_word(), '0, 0);
        step(1, 7, 2, rnd_word(), rnd_word(), rnd_word(), 5);
        // R11: idle cycles keep the result
        step(0, 3, 0, rnd_word(), rnd_word(), '0, 0);
        step(0, 0, 1, rnd_word(), rnd_word(), rnd_word(), 3);
        // random mix, all ops, widths and shifts (R1 width codes 0..3)
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 5) != 0, int'($urandom % 8), int'($urandom % 4),
                 rnd_word(), rnd_word(), rnd_word(), int'($urandom % 64));
        end
        step(0, 0, 0, '0, '0, '0, 0);
        @(negedge clk);
        check_now();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule